// File: doc/BRIEF.md
# Bidirectional Stream Prefetcher

This block watches the demand accesses of a load/store port and looks for short runs of accesses that walk through memory one cache line at a time. It keeps two small tracking tables. The larger one follows runs that climb in address and the smaller one follows runs that fall. When an access lands on the line right next to a tracked line, in that table's direction, the run is taken to be continuing. The block then queues one prefetch for the following line in the same direction, and the entry moves forward to the line just accessed.

An access that matches nothing opens a new climbing entry, which replaces the least recently touched one. A falling entry is opened only when an unmatched access sits exactly one line below a live climbing entry. Every entry carries a small age count that advances on each access and clears when the entry is touched. An entry whose age saturates is dead, so an old run cannot start a prefetch. A prefetch whose target would leave the 4 KB page of the access is discarded. Requests wait in a two-slot queue and leave through a valid/ready handshake.

Top module: `stream_prefetcher`

## Requirements
- R1: Lines are 64 bytes. Only address bits [31:6] take part in matching, and `pf_line` carries the line number, which is the byte address shifted right by 6.
- R2: An access whose line is one above a live climbing entry queues a prefetch of access line + 1. That entry then holds the access line, so a steady climb produces one prefetch per access.
- R3: An access whose line is one below a live falling entry queues a prefetch of access line - 1. That entry then holds the access line.
- R4: A falling entry is created only by an unmatched access that is one line below a live climbing entry. Creating an entry never queues a prefetch, and an access two lines away from an entry is not a match.
- R5: An unmatched access always opens a climbing entry. The 12-entry climbing table fills empty slots first and then replaces the entry left untouched for the most accesses.
- R6: Each entry has a 4-bit age that is cleared when the entry is written and incremented by every later access. An entry still matches with 14 other accesses between its last write and the matching access. With 15 it is dead and does not match.
- R7: When one access matches both tables, only the climbing prefetch is queued.
- R8: A prefetch whose target line lies in a different 4 KB page from the access is not queued, but the matching entry still advances. This holds in both directions.
- R9: Requests leave in arrival order from a 2-deep queue. A request produced while the queue holds 2 requests is dropped.
- R10: After reset `pf_valid` is low and both tables are empty, so no access made before reset can match.
- R11: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_addr | input | 32 | Byte address of the demand access |
| pf_ready | input | 1 | Consumer accepts the presented prefetch |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_line | output | 26 | Line number of the presented prefetch |

## Verification
The bench targets the exact edge of the age window: one run has 14 intervening accesses and another has 15. A counter that is off by one either revives a dead entry or kills a live one, and so adds or loses a prefetch. It fills the climbing table and adds a thirteenth entry, so that picking the wrong victim loses the run that should survive or keeps the one that should be gone. Page crossings are driven in both directions and are followed by one more access. A design that still issues the crossing prefetch, or that fails to advance the entry, shows up as an extra or a missing request. It also presents an access that matches both tables, and it stalls the consumer while three requests arrive, which exposes double issue, overwritten queue slots and reordering.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int ADDR_W      = 32;
    localparam int LINE_BITS   = 6;
    localparam int PAGE_BITS   = 12;
    localparam int AGE_W       = 4;
    localparam int LINE_W      = ADDR_W - LINE_BITS;
    localparam int PAGE_SLOT_W = PAGE_BITS - LINE_BITS;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [AGE_W-1:0]  age_t;

    localparam age_t AGE_DEAD = '1;

    typedef struct packed {
        line_t line;
        age_t  age;
    } track_t;

    function automatic logic same_page(line_t a, line_t b);
        return a[LINE_W-1:PAGE_SLOT_W] == b[LINE_W-1:PAGE_SLOT_W];
    endfunction

endpackage

// File: rtl/spf_track_table.sv
module spf_track_table
    import spf_pkg::*;
#(
    parameter int ENTRIES = 12,
    parameter bit ASCEND  = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_valid,
    input  line_t acc_line,
    input  line_t probe_line,
    input  logic  upd_en,
    input  logic  alloc_en,
    output logic  hit,
    output logic  probe_hit
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    track_t               ent_q [ENTRIES];
    logic [ENTRIES-1:0]   live;
    logic [ENTRIES-1:0]   adj;
    logic [ENTRIES-1:0]   probe_eq;
    logic [IDX_W-1:0]     hit_idx;
    logic [IDX_W-1:0]     victim;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign live[i] = ent_q[i].age != AGE_DEAD;
        if (ASCEND) begin : g_up
            assign adj[i] = live[i] && (acc_line == ent_q[i].line + line_t'(1));
        end else begin : g_dn
            assign adj[i] = live[i] && (acc_line == ent_q[i].line - line_t'(1));
        end
        assign probe_eq[i] = live[i] && (probe_line == ent_q[i].line);
    end

    assign hit       = |adj;
    assign probe_hit = |probe_eq;

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (adj[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        logic found;
        age_t oldest;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!live[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        oldest = ent_q[0].age;
        if (!found) begin
            for (int i = 1; i < ENTRIES; i++) begin
                if (ent_q[i].age > oldest) begin
                    oldest = ent_q[i].age;
                    victim = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '{line: '0, age: AGE_DEAD};
            end
        end else if (acc_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (upd_en && hit && hit_idx == IDX_W'(i)) begin
                    ent_q[i] <= '{line: acc_line, age: '0};
                end else if (alloc_en && victim == IDX_W'(i)) begin
                    ent_q[i] <= '{line: acc_line, age: '0};
                end else if (live[i]) begin
                    ent_q[i].age <= ent_q[i].age + age_t'(1);
                end
            end
        end
    end

    // R2
    upd_alloc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && upd_en && hit) |-> !alloc_en);

endmodule

// File: rtl/spf_req_fifo.sv
module spf_req_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  line_t push_line,
    input  logic  pop_ready,
    output logic  out_valid,
    output line_t out_line
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    line_t            slot_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign out_valid = count != '0;
    assign out_line  = slot_q[rd_ptr];
    assign do_pop    = out_valid && pop_ready;
    assign do_push   = push && (count != CNT_W'(DEPTH));

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (do_push) begin
                slot_q[wr_ptr] <= push_line;
                wr_ptr         <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_line)));

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import spf_pkg::*;
#(
    parameter int ASC_ENTRIES = 12,
    parameter int DSC_ENTRIES = 4,
    parameter int Q_DEPTH     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);
    line_t acc_line;
    logic  asc_hit, dsc_hit, asc_probe, dsc_probe;
    logic  asc_upd, dsc_upd, no_match, dsc_alloc;
    line_t target;
    logic  push;

    assign acc_line  = acc_addr[ADDR_W-1:LINE_BITS];
    assign asc_upd   = asc_hit;
    assign dsc_upd   = !asc_hit && dsc_hit;
    assign no_match  = !asc_hit && !dsc_hit;
    assign dsc_alloc = no_match && asc_probe && !dsc_probe;
    assign target    = asc_hit ? acc_line + line_t'(1) : acc_line - line_t'(1);
    assign push      = acc_valid && !no_match && same_page(target, acc_line);

    spf_track_table #(.ENTRIES(ASC_ENTRIES), .ASCEND(1'b1)) u_up (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_line   (acc_line),
        .probe_line (acc_line + line_t'(1)),
        .upd_en     (asc_upd),
        .alloc_en   (no_match),
        .hit        (asc_hit),
        .probe_hit  (asc_probe)
    );

    spf_track_table #(.ENTRIES(DSC_ENTRIES), .ASCEND(1'b0)) u_down (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_line   (acc_line),
        .probe_line (acc_line),
        .upd_en     (dsc_upd),
        .alloc_en   (dsc_alloc),
        .hit        (dsc_hit),
        .probe_hit  (dsc_probe)
    );

    spf_req_fifo #(.DEPTH(Q_DEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_line (target),
        .pop_ready (pf_ready),
        .out_valid (pf_valid),
        .out_line  (pf_line)
    );

    // R8
    page_guard_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (target[PAGE_SLOT_W-1:0] != (asc_hit ? PAGE_SLOT_W'(0) : {PAGE_SLOT_W{1'b1}})));

endmodule

// File: tb/stream_prefetcher_test.sv
`timescale 1ns/1ps
module stream_prefetcher_test;
    import spf_pkg::*;

    typedef struct {
        line_t line;
        string req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              pf_ready = 1'b1;
    logic              pf_valid;
    logic [LINE_W-1:0] pf_line;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    stream_prefetcher uut (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: compares each accepted request with the scoreboard head
    always @(negedge clk) begin
        if (!rst && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected prefetch", longint'(pf_line), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(pf_line == e.line, e.req, "prefetch line", longint'(pf_line), longint'(e.line));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        pf_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(line_t l, bit expect_pf, line_t exp_line, string req);
        acc_valid = 1'b1;
        acc_addr  = {l, LINE_BITS'(l[5:0] ^ 6'h2b)};
        if (expect_pf) exp_q.push_back('{line: exp_line, req: req});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic drained(string req);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && !pf_valid, req, "queue drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        do_reset();
        // R10 reset state
        check(pf_valid == 1'b0, "R10", "pf_valid after reset", pf_valid, 0);
        access(26'h500, 0, '0, "R10");
        do_reset();
        access(26'h501, 0, '0, "R10");
        drained("R10");

        // R2 and R1: steady climb with varying byte offsets
        access(26'h1010, 0, '0, "R2");
        access(26'h1011, 1, 26'h1012, "R1");
        access(26'h1012, 1, 26'h1013, "R2");
        access(26'h1013, 1, 26'h1014, "R2");
        drained("R2");

        // R2 interleaved streams
        access(26'h2010, 0, '0, "R2");
        access(26'h3010, 0, '0, "R2");
        access(26'h2011, 1, 26'h2012, "R2");
        access(26'h3011, 1, 26'h3012, "R2");
        access(26'h2012, 1, 26'h2013, "R2");
        drained("R2");

        // R3 and R4: falling run
        access(26'h4021, 0, '0, "R4");
        access(26'h4020, 0, '0, "R4");
        access(26'h401F, 1, 26'h401E, "R3");
        access(26'h401E, 1, 26'h401D, "R3");
        drained("R3");

        // R4: a two-line gap is no match and creation is silent
        access(26'h6030, 0, '0, "R4");
        access(26'h602E, 0, '0, "R4");
        access(26'h602D, 0, '0, "R4");
        drained("R4");

        // R7: both tables match, climbing wins
        access(26'h7042, 0, '0, "R7");
        access(26'h7041, 0, '0, "R7");
        access(26'h703F, 0, '0, "R7");
        access(26'h7040, 1, 26'h7041, "R7");
        drained("R7");

        // R8: page crossing, climbing then falling
        access(26'h803E, 0, '0, "R8");
        access(26'h803F, 0, '0, "R8");
        access(26'h8040, 1, 26'h8041, "R8");
        access(26'h9042, 0, '0, "R8");
        access(26'h9041, 0, '0, "R8");
        access(26'h9040, 0, '0, "R8");
        access(26'h903F, 1, 26'h903E, "R8");
        drained("R8");

        // R5: fill 12 slots, thirteenth evicts the oldest
        do_reset();
        for (int i = 0; i < 12; i++) access(line_t'(26'hA000 + 4 * i), 0, '0, "R5");
        access(26'hB000, 0, '0, "R5");
        access(26'hA005, 1, 26'hA006, "R5");
        access(26'hA001, 0, '0, "R5");
        drained("R5");

        // R6: 14 intervening accesses keep the entry live
        do_reset();
        access(26'hC000, 0, '0, "R6");
        access(26'hD000, 0, '0, "R6");
        for (int k = 1; k <= 13; k++) access(line_t'(26'hD000 + k), 1, line_t'(26'hD001 + k), "R6");
        access(26'hC001, 1, 26'hC002, "R6");
        drained("R6");

        // R6: 15 intervening accesses kill the entry
        do_reset();
        access(26'hC000, 0, '0, "R6");
        access(26'hD000, 0, '0, "R6");
        for (int k = 1; k <= 14; k++) access(line_t'(26'hD000 + k), 1, line_t'(26'hD001 + k), "R6");
        access(26'hC001, 0, '0, "R6");
        drained("R6");

        // R9 and R11: stalled consumer, third request dropped
        do_reset();
        pf_ready = 1'b0;
        access(26'hE000, 0, '0, "R9");
        access(26'hE001, 1, 26'hE002, "R9");
        access(26'hE002, 1, 26'hE003, "R9");
        access(26'hE003, 0, '0, "R9");
        repeat (2) @(negedge clk);
        check(pf_valid == 1'b1, "R11", "valid held under stall", pf_valid, 1);
        check(pf_line == 26'hE002, "R11", "line held under stall", longint'(pf_line), 26'hE002);
        pf_ready = 1'b1;
        drained("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule